// File: doc/BRIEF.md
# Instruction Fetch Address Breakpoint Unit

This block watches the start address of every instruction fetch. The address is formed from an 8-bit bank and a 16-bit program counter. The block compares that address against two programmable 24-bit compare registers. One of four conditions is selected in a control register:

- equality with compare register 0;
- equality with compare register 1;
- equality with either register;
- the address falling outside the window that the two registers bound.

When the selected condition holds and detection is enabled, the block does two things. In the same cycle as the fetch strobe, it tells the core not to execute the fetched instruction. It also raises a non-maskable interrupt request, which stays pending until it is acknowledged.

Software reaches four registers through a small read/write port. The two compare registers are only reachable while an access-enable bit is set. Software sets that bit in the instruction just before the access and clears it in the instruction just after. In either-register mode, a read-only decision bit records which register caused the last detection.

Top module: `fetch_bkpt_unit`

## Requirements
- R1: After synchronous reset, all registers read zero, `irq_req` is 0 and `exec_suppress` is 0.
- R2: Register map on `reg_sel`:
  - 0 is control 0: bit 0 is detect enable, bits 2:1 are the condition.
  - 1 is control 1: bit 0 is access enable (read/write), bit 1 is the decision bit (read-only).
  - 2 is compare 0 and 3 is compare 1 (24 bits each).
  - Unused bits read 0. A write takes effect on the next cycle.
- R3: With condition 00, a valid fetch whose full 24-bit address equals compare 0 asserts `exec_suppress` in the same cycle. Any other address does not.
- R4: With condition 01, a valid fetch whose address equals compare 1 asserts `exec_suppress` in the same cycle.
- R5: With condition 10, a valid fetch equal to either compare register is detected. The decision bit is updated on that detection: 0 when compare 0 matched (including when both match) and 1 when only compare 1 matched. In the other conditions the decision bit keeps its value.
- R6: With condition 11, a valid fetch is detected when its address is strictly below compare 0 or strictly above compare 1. Addresses equal to either bound are not detected.
- R7: While detect enable is 0, no fetch asserts `exec_suppress` or sets `irq_req`.
- R8: While access enable is 0, reads of the compare registers return zero and writes to them are ignored.
- R9: A detection sets `irq_req` from the next cycle. It stays set until a cycle with `irq_ack` high and no new detection. A detection in the same cycle as `irq_ack` keeps it set.
- R10: `exec_suppress` is never asserted when `fetch_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Instruction fetch start strobe |
| fetch_addr | input | 24 | Bank (23:16) and program counter (15:0) of the fetched instruction |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational on `reg_sel`) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_req | output | 1 | Pending non-maskable interrupt request |
| exec_suppress | output | 1 | Do not execute the instruction fetched this cycle |

## Verification
Two situations are hard to reach from the ports:
- An acknowledge that lands in the same cycle as a fresh detection.
- The either-register case where both compare registers hold the same address, so the decision bit must favour register 0.

The stimulus reaches the first by holding `irq_ack` high on the exact cycle of a matching fetch. It reaches the second by programming both registers, under the access unlock, to one value before fetching that address. The window condition is driven at each bound and at one step past it, because those edges are where a comparison direction error would show.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    typedef enum logic [1:0] {
        DET_CMP0    = 2'b00,
        DET_CMP1    = 2'b01,
        DET_EITHER  = 2'b10,
        DET_OUTSIDE = 2'b11
    } det_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL0 = 2'd0,
        SEL_CTRL1 = 2'd1,
        SEL_CMP0  = 2'd2,
        SEL_CMP1  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        det_mode_e mode;
        logic      enable;
    } ctrl0_t;

    typedef struct packed {
        logic decision;
        logic access;
    } ctrl1_t;

    typedef struct packed {
        logic hit;
        logic by_cmp1;
    } cond_t;

    localparam int NUM_CMP = 2;

    function automatic logic in_window(input logic [63:0] a,
                                       input logic [63:0] lo,
                                       input logic [63:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/fbu_regs.sv
module fbu_regs
    import fbu_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              dec_set,
    input  logic              dec_val,
    output ctrl0_t            ctrl0,
    output logic [ADDR_W-1:0] cmp0,
    output logic [ADDR_W-1:0] cmp1
);
    localparam int C0_W = $bits(ctrl0_t);
    localparam int C1_W = $bits(ctrl1_t);

    ctrl0_t            ctrl0_q;
    ctrl1_t            ctrl1_q;
    logic [ADDR_W-1:0] cmp_q [NUM_CMP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0_q <= '0;
        end else if (reg_wr && reg_sel == SEL_CTRL0) begin
            ctrl0_q <= ctrl0_t'(reg_wdata[C0_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl1_q <= '0;
        end else begin
            if (reg_wr && reg_sel == SEL_CTRL1) begin
                ctrl1_q.access <= reg_wdata[0];
            end
            if (dec_set) begin
                ctrl1_q.decision <= dec_val;
            end
        end
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam logic [1:0] MY_SEL = 2'(SEL_CMP0) + 2'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[g] <= '0;
            end else if (reg_wr && ctrl1_q.access && reg_sel == MY_SEL) begin
                cmp_q[g] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL0: reg_rdata[C0_W-1:0] = ctrl0_q;
            SEL_CTRL1: reg_rdata[C1_W-1:0] = ctrl1_q;
            SEL_CMP0:  reg_rdata = ctrl1_q.access ? cmp_q[0] : '0;
            default:   reg_rdata = ctrl1_q.access ? cmp_q[1] : '0;
        endcase
    end

    assign ctrl0 = ctrl0_q;
    assign cmp0  = cmp_q[0];
    assign cmp1  = cmp_q[1];

    // R8
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !ctrl1_q.access && reg_sel == SEL_CMP0) |=> $stable(cmp_q[0]));

    // R5
    decision_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_set |=> $stable(ctrl1_q.decision));

endmodule

// File: rtl/fbu_cmp.sv
module fbu_cmp
    import fbu_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] cmp0,
    input  logic [ADDR_W-1:0] cmp1,
    input  det_mode_e         mode,
    output cond_t             cond
);
    logic eq0, eq1, below, above;

    assign eq0   = (addr == cmp0);
    assign eq1   = (addr == cmp1);
    assign below = (addr < cmp0);
    assign above = (addr > cmp1);

    always_comb begin
        cond = '0;
        case (mode)
            DET_CMP0:   cond.hit = eq0;
            DET_CMP1:   cond.hit = eq1;
            DET_EITHER: begin
                cond.hit     = eq0 | eq1;
                cond.by_cmp1 = !eq0;
            end
            default:    cond.hit = below | above;
        endcase
    end

    // R6
    window_bounds_chk: assert final (
        !(mode == DET_OUTSIDE && cmp0 <= cmp1 &&
          in_window(64'(addr), 64'(cmp0), 64'(cmp1)) && cond.hit));

endmodule

// File: rtl/fbu_pend.sv
module fbu_pend (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)      pend <= 1'b0;
        else if (set) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

    // R9
    set_pend_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pend);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);

endmodule

// File: rtl/fetch_bkpt_unit.sv
module fetch_bkpt_unit
    import fbu_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int PC_W   = 16,
    localparam int ADDR_W = BANK_W + PC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic              exec_suppress
);
    ctrl0_t            ctrl0;
    logic [ADDR_W-1:0] cmp0, cmp1;
    cond_t             cond;
    logic              fire;
    logic              dec_set;

    fbu_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dec_set   (dec_set),
        .dec_val   (cond.by_cmp1),
        .ctrl0     (ctrl0),
        .cmp0      (cmp0),
        .cmp1      (cmp1)
    );

    fbu_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr (fetch_addr),
        .cmp0 (cmp0),
        .cmp1 (cmp1),
        .mode (ctrl0.mode),
        .cond (cond)
    );

    fbu_pend u_pend (
        .clk  (clk),
        .rst  (rst),
        .set  (fire),
        .clr  (irq_ack),
        .pend (irq_req)
    );

    assign fire          = fetch_valid && ctrl0.enable && cond.hit;
    assign dec_set       = fire && (ctrl0.mode == DET_EITHER);
    assign exec_suppress = fire;

    // R10
    suppress_needs_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        exec_suppress |-> fetch_valid);

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl0.enable |-> !exec_suppress);

    // R7
    disabled_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl0.enable && !irq_req) |=> !irq_req);

endmodule

// File: tb/test_fetch_bkpt_unit.sv
`timescale 1ns/1ps
module test_fetch_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic        exec_suppress;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_en, m_acc, m_dec, m_irq;
    int          m_mode;
    logic [23:0] m_c0, m_c1;

    always #2.5 clk = ~clk;

    fetch_bkpt_unit i_fetch_bkpt_unit (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_req(irq_req), .exec_suppress(exec_suppress)
    );

    task automatic check(input string tag, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit fv, input logic [23:0] fa, input logic [1:0] sel,
                       input bit wr, input logic [23:0] wd, input bit ack,
                       input string tag);
        bit cond_e, fire_e, eq0, eq1;
        logic [23:0] rd_e;
        @(negedge clk);
        fetch_valid = fv; fetch_addr = fa; reg_sel = sel;
        reg_wr = wr; reg_wdata = wd; irq_ack = ack;
        #1;
        eq0 = (fa == m_c0);
        eq1 = (fa == m_c1);
        case (m_mode)
            0: cond_e = eq0;
            1: cond_e = eq1;
            2: cond_e = eq0 || eq1;
            default: cond_e = (fa < m_c0) || (fa > m_c1);
        endcase
        fire_e = fv && m_en && cond_e;
        case (sel)
            2'd0: rd_e = {21'd0, 2'(m_mode), m_en};
            2'd1: rd_e = {22'd0, m_dec, m_acc};
            2'd2: rd_e = m_acc ? m_c0 : 24'd0;
            default: rd_e = m_acc ? m_c1 : 24'd0;
        endcase
        check(tag, "exec_suppress", {23'd0, exec_suppress}, {23'd0, fire_e});
        check(tag, "irq_req", {23'd0, irq_req}, {23'd0, m_irq});
        check(tag, "reg_rdata", reg_rdata, rd_e);
        @(posedge clk);
        if (fire_e && m_mode == 2) m_dec = !eq0;
        if (fire_e) m_irq = 1;
        else if (ack) m_irq = 0;
        if (wr) begin
            case (sel)
                2'd0: begin m_en = wd[0]; m_mode = int'(wd[2:1]); end
                2'd1: m_acc = wd[0];
                2'd2: if (m_acc) m_c0 = wd;
                default: if (m_acc) m_c1 = wd;
            endcase
        end
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [23:0] d, input string tag);
        cyc(0, 24'h0, sel, 1, d, 0, tag);
    endtask

    task automatic rreg(input logic [1:0] sel, input string tag);
        cyc(0, 24'h0, sel, 0, 24'h0, 0, tag);
    endtask

    task automatic fetch(input logic [23:0] a, input string tag);
        cyc(1, a, 2'd1, 0, 24'h0, 0, tag);
    endtask

    task automatic set_cmp(input logic [23:0] a, input logic [23:0] b, input string tag);
        wreg(2'd1, 24'h1, tag);
        wreg(2'd2, a, tag);
        wreg(2'd3, b, tag);
        wreg(2'd1, 24'h0, tag);
    endtask

    initial begin
        m_en = 0; m_acc = 0; m_dec = 0; m_irq = 0; m_mode = 0; m_c0 = '0; m_c1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        for (int s = 0; s < 4; s++) rreg(2'(s), "R1");
        // R8 locked access
        wreg(2'd2, 24'hABCDEF, "R8");
        wreg(2'd1, 24'h1, "R2");
        rreg(2'd2, "R8");
        wreg(2'd2, 24'h123456, "R2");
        wreg(2'd3, 24'h123500, "R2");
        rreg(2'd2, "R2"); rreg(2'd3, "R2"); rreg(2'd1, "R2");
        wreg(2'd1, 24'h0, "R8");
        rreg(2'd3, "R8");
        wreg(2'd3, 24'h000001, "R8");
        // R7 detect disabled
        fetch(24'h123456, "R7");
        cyc(0, 24'h0, 2'd0, 0, 24'h0, 0, "R7");
        // R3 equality with compare 0
        wreg(2'd0, 24'h1, "R3");
        rreg(2'd0, "R2");
        fetch(24'h023456, "R3");
        fetch(24'h123457, "R3");
        fetch(24'h123456, "R3");
        // R10 fetch_valid low with matching address
        cyc(0, 24'h123456, 2'd1, 0, 24'h0, 0, "R10");
        // R9 hold, then ack together with detection, then clear
        repeat (3) rreg(2'd0, "R9");
        cyc(1, 24'h123456, 2'd1, 0, 24'h0, 1, "R9");
        cyc(0, 24'h0, 2'd1, 0, 24'h0, 1, "R9");
        rreg(2'd0, "R9");
        // R4 compare 1
        wreg(2'd0, 24'h3, "R4");
        fetch(24'h123456, "R4");
        fetch(24'h123500, "R4");
        cyc(0, 24'h0, 2'd1, 0, 24'h0, 1, "R4");
        // R5 either register with decision bit
        wreg(2'd0, 24'h5, "R5");
        fetch(24'h123500, "R5");
        rreg(2'd1, "R5");
        fetch(24'h123456, "R5");
        rreg(2'd1, "R5");
        fetch(24'h123500, "R5");
        wreg(2'd0, 24'h1, "R5");
        fetch(24'h123456, "R5");
        rreg(2'd1, "R5");
        wreg(2'd0, 24'h5, "R5");
        set_cmp(24'h777777, 24'h777777, "R5");
        fetch(24'h777777, "R5");
        rreg(2'd1, "R5");
        cyc(0, 24'h0, 2'd1, 0, 24'h0, 1, "R5");
        // R6 outside window
        set_cmp(24'h100000, 24'h1FFFFF, "R6");
        wreg(2'd0, 24'h7, "R6");
        fetch(24'h0FFFFF, "R6");
        fetch(24'h100000, "R6");
        fetch(24'h150000, "R6");
        fetch(24'h1FFFFF, "R6");
        fetch(24'h200000, "R6");
        fetch(24'h000000, "R6");
        cyc(0, 24'h0, 2'd1, 0, 24'h0, 1, "R6");
        rreg(2'd1, "R6");
        // R7 disable again inside the window mode
        wreg(2'd0, 24'h6, "R7");
        fetch(24'hFFFFFF, "R7");
        rreg(2'd0, "R7");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule